// File: doc/BRIEF.md
# Shared-RAM Host Access Window

This block gives a host a small register window into a byte-wide RAM that it shares with a coprocessor. The host sees four byte registers. A control/status register starts and stops the coprocessor, pulses an interrupt request toward it, holds the address auto-increment mode, and shows two interrupt flags that the coprocessor raises. Two address registers load the low and high bytes of a 16-bit pointer. A data register reads or writes the RAM byte at that pointer.

With auto-increment on, every data-register access advances the pointer by one. A whole message can then be streamed after one address load. The pointer wraps from 0xFFFF to 0x0000. The RAM has a second, independent port for the coprocessor. Software uses the two ports to hand messages across. A common use is a liveness byte: the coprocessor writes 0xFF into it, and the host reads the byte and writes 0 back to re-arm the check.

Host accesses are single-cycle and take effect at the clock edge. Reads return the selected register combinationally within the access cycle. The RAM holds 2^RAM_AW bytes and is indexed by the low RAM_AW bits of the pointer.

Top module: `shared_ram_window`

## Requirements
- R1: After reset the status register reads 0x00, both address bytes read 0x00, and copRun, copIrq and hostIrq are low.
- R2: Register select 1 loads the pointer's low byte and select 2 loads its high byte. Each load leaves the other byte unchanged, and reading the same select returns that byte.
- R3: A data-register access (select 3) writes or returns the RAM byte at the pointer. Bytes written on one port are visible on the other port, including a liveness byte that the coprocessor sets to 0xFF and the host clears to 0x00.
- R4: With auto-increment set (status bit 1), each data-register access advances the pointer by one for the next cycle. With it clear, the pointer does not move.
- R5: An auto-increment step from pointer 0xFFFF gives 0x0000.
- R6: A write to select 0 stores bit 0 (run) and bit 1 (auto-increment). copRun follows the run bit, and a status read returns both bits.
- R7: A control write with bits 2 and 0 both set drives copIrq high for exactly the following cycle. With bit 0 clear there is no pulse. Status bit 2 always reads 0.
- R8: A one-cycle pulse on copSetInt0 or copSetInt1 sets flag 0 (status bit 4) or flag 1 (status bit 5). hostIrq is the OR of the two flags.
- R9: A control write with bit 4 or bit 5 set clears that flag only. Writing a 0 in a flag bit leaves that flag unchanged.
- R10: When a set pulse and a host clear of the same flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostReg | input | 2 | Register select: 0 control/status, 1 address low, 2 address high, 3 data |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Selected register contents |
| hostIrq | output | 1 | Interrupt to the host, OR of the two flags |
| copRun | output | 1 | Coprocessor run enable |
| copIrq | output | 1 | One-cycle interrupt pulse to the coprocessor |
| copSetInt0 | input | 1 | Coprocessor set strobe for flag 0 |
| copSetInt1 | input | 1 | Coprocessor set strobe for flag 1 |
| copAddr | input | RAM_AW | Coprocessor RAM address |
| copWe | input | 1 | Coprocessor RAM write enable |
| copWdata | input | 8 | Coprocessor RAM write data |
| copRdata | output | 8 | Coprocessor RAM read data at copAddr |

## Verification
A pointer that is wrong inside the block shows up on the very next data access. The byte returned, or the byte that lands in RAM and is then seen on copRdata, differs from the bench's shadow memory. The bench also reads both address bytes back directly. A wrong flag or control bit appears at once on hostIrq or copRun, or on the next status read. A stuck or missing coprocessor interrupt shows on copIrq in the cycle that follows the control write. Random traffic keeps a full shadow of pointer, flags and memory, so a divergence is reported within the access where it first becomes visible.

// File: rtl/shram_pkg.sv
package shram_pkg;
  localparam int PTR_W = 16;

  localparam logic [1:0] REG_CTL  = 2'd0;
  localparam logic [1:0] REG_ALO  = 2'd1;
  localparam logic [1:0] REG_AHI  = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int BIT_RUN  = 0;
  localparam int BIT_AUTO = 1;
  localparam int BIT_IRQ  = 2;
  localparam int BIT_INT0 = 4;
  localparam int NUM_INT  = 2;

  typedef struct packed {
    logic       ldLo;
    logic       ldHi;
    logic       ramWr;
    logic       step;
    logic [7:0] wdata;
  } winStrobe_t;
endpackage

// File: rtl/shram_ctrl.sv
module shram_ctrl
  import shram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWe,
  input  logic [1:0] hostReg,
  input  logic [7:0] hostWdata,
  input  logic       copSetInt0,
  input  logic       copSetInt1,
  output winStrobe_t strb,
  output logic [7:0] statusByte,
  output logic       copRun,
  output logic       copIrq,
  output logic       hostIrq
);
  logic run, autoInc, irqPulse;
  logic ctlWr, dataAcc;
  logic [NUM_INT-1:0] intFlag, intSet, ackHit;

  assign ctlWr   = hostSel && hostWe && (hostReg == REG_CTL);
  assign dataAcc = hostSel && (hostReg == REG_DATA);
  assign intSet  = {copSetInt1, copSetInt0};

  always_comb begin
    strb.ldLo  = hostSel && hostWe && (hostReg == REG_ALO);
    strb.ldHi  = hostSel && hostWe && (hostReg == REG_AHI);
    strb.ramWr = dataAcc && hostWe;
    strb.step  = dataAcc && autoInc;
    strb.wdata = hostWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run      <= 1'b0;
      autoInc  <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= ctlWr && hostWdata[BIT_IRQ] && hostWdata[BIT_RUN];
      if (ctlWr) begin
        run     <= hostWdata[BIT_RUN];
        autoInc <= hostWdata[BIT_AUTO];
      end
    end
  end

  for (genvar i = 0; i < NUM_INT; i++) begin : g_flag
    assign ackHit[i] = ctlWr && hostWdata[BIT_INT0 + i];

    always_ff @(posedge clk) begin
      if (!rstN)          intFlag[i] <= 1'b0;
      else if (intSet[i]) intFlag[i] <= 1'b1;
      else if (ackHit[i]) intFlag[i] <= 1'b0;
    end

    // R10: a set strobe always leaves the flag set
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
      intSet[i] |=> intFlag[i]);
    // R9: a flag only drops after a host acknowledge of that flag
    p_clear_only_on_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
      $fell(intFlag[i]) |-> $past(ackHit[i]));
  end

  always_comb begin
    statusByte = '0;
    statusByte[BIT_RUN]  = run;
    statusByte[BIT_AUTO] = autoInc;
    for (int i = 0; i < NUM_INT; i++) statusByte[BIT_INT0 + i] = intFlag[i];
  end

  assign copRun  = run;
  assign copIrq  = irqPulse;
  assign hostIrq = |intFlag;

  // R7: the request to the coprocessor is never held without a fresh write
  p_irq_not_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> !copIrq);
  // R6: run changes only through a control write
  p_run_by_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWr |=> $stable(copRun));
endmodule

// File: rtl/shram_datapath.sv
module shram_datapath
  import shram_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        strb,
  input  logic [1:0]        hostReg,
  input  logic [7:0]        statusByte,
  input  logic [RAM_AW-1:0] copAddr,
  input  logic              copWe,
  input  logic [7:0]        copWdata,
  output logic [7:0]        hostRdata,
  output logic [7:0]        copRdata
);
  localparam int RAM_DEPTH = 1 << RAM_AW;

  logic [PTR_W-1:0] curAddr;
  logic [RAM_AW-1:0] ramIdx;
  logic [7:0] mem [RAM_DEPTH];

  assign ramIdx = curAddr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN)          curAddr <= '0;
    else if (strb.ldLo) curAddr <= {curAddr[PTR_W-1:8], strb.wdata};
    else if (strb.ldHi) curAddr <= {strb.wdata, curAddr[7:0]};
    else if (strb.step) curAddr <= curAddr + 16'd1;
  end

  // host write placed last: on a same-address collision the host byte lands
  always_ff @(posedge clk) begin
    if (copWe)      mem[copAddr] <= copWdata;
    if (strb.ramWr) mem[ramIdx]  <= strb.wdata;
  end

  always_comb begin
    case (hostReg)
      REG_CTL: hostRdata = statusByte;
      REG_ALO: hostRdata = curAddr[7:0];
      REG_AHI: hostRdata = curAddr[PTR_W-1:8];
      default: hostRdata = mem[ramIdx];
    endcase
  end

  assign copRdata = mem[copAddr];

  // R4: a step moves the pointer by exactly one
  p_step_one_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && curAddr != 16'hFFFF) |=> curAddr == $past(curAddr) + 16'd1);
  // R5: the pointer wraps to zero
  p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && curAddr == 16'hFFFF) |=> curAddr == 16'h0000);
  // R4: without a load or a step the pointer holds
  p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.ldLo || strb.ldHi || strb.step) |=> $stable(curAddr));
  // R2: a low-byte load keeps the high byte
  p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldLo |=> curAddr[PTR_W-1:8] == $past(curAddr[PTR_W-1:8]));
endmodule

// File: rtl/shared_ram_window.sv
module shared_ram_window
  import shram_pkg::*;
#(
  parameter int RAM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [1:0]        hostReg,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              hostIrq,
  output logic              copRun,
  output logic              copIrq,
  input  logic              copSetInt0,
  input  logic              copSetInt1,
  input  logic [RAM_AW-1:0] copAddr,
  input  logic              copWe,
  input  logic [7:0]        copWdata,
  output logic [7:0]        copRdata
);
  winStrobe_t strb;
  logic [7:0] statusByte;

  shram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe),
    .hostReg(hostReg), .hostWdata(hostWdata),
    .copSetInt0(copSetInt0), .copSetInt1(copSetInt1),
    .strb(strb), .statusByte(statusByte),
    .copRun(copRun), .copIrq(copIrq), .hostIrq(hostIrq)
  );

  shram_datapath #(.RAM_AW(RAM_AW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .hostReg(hostReg),
    .statusByte(statusByte), .copAddr(copAddr), .copWe(copWe),
    .copWdata(copWdata), .hostRdata(hostRdata), .copRdata(copRdata)
  );
endmodule

// File: tb/shared_ram_window_tb.sv
module shared_ram_window_tb;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 0, hostWe = 0;
  logic [1:0] hostReg = 0;
  logic [7:0] hostWdata = 0;
  logic [7:0] hostRdata, copRdata;
  logic hostIrq, copRun, copIrq;
  logic copSetInt0 = 0, copSetInt1 = 0;
  logic [AW-1:0] copAddr = 0;
  logic copWe = 0;
  logic [7:0] copWdata = 0;

  always #4 clk = ~clk;

  shared_ram_window #(.RAM_AW(AW)) u_dut (.*);

  int nChecks = 0, nFail = 0;
  logic [15:0] mAddr = 0;
  bit mRun = 0, mAuto = 0, mI0 = 0, mI1 = 0;
  logic [7:0] mMem [DEPTH];

  function automatic logic [7:0] expStatus();
    return {2'b00, mI1, mI0, 2'b00, mAuto, mRun};
  endfunction

  function automatic logic [7:0] patt(int i);
    return 8'(i * 37 + 11);
  endfunction

  task automatic check(string req, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [1:0] r, logic [7:0] d);
    @(negedge clk);
    hostSel = 1; hostWe = 1; hostReg = r; hostWdata = d;
    @(posedge clk); #1;
    hostSel = 0; hostWe = 0;
    case (r)
      2'd0: begin
        mRun = d[0]; mAuto = d[1];
        if (d[4]) mI0 = 0;
        if (d[5]) mI1 = 0;
      end
      2'd1: mAddr[7:0] = d;
      2'd2: mAddr[15:8] = d;
      default: begin mMem[mAddr[AW-1:0]] = d; if (mAuto) mAddr++; end
    endcase
  endtask

  task automatic hread(logic [1:0] r, string req);
    logic [7:0] e;
    @(negedge clk);
    hostSel = 1; hostWe = 0; hostReg = r;
    #1;
    case (r)
      2'd0: e = expStatus();
      2'd1: e = mAddr[7:0];
      2'd2: e = mAddr[15:8];
      default: e = mMem[mAddr[AW-1:0]];
    endcase
    check(req, hostRdata, e);
    @(posedge clk); #1;
    hostSel = 0;
    if (r == 2'd3 && mAuto) mAddr++;
  endtask

  task automatic copSet(bit s0, bit s1);
    @(negedge clk);
    copSetInt0 = s0; copSetInt1 = s1;
    @(posedge clk); #1;
    copSetInt0 = 0; copSetInt1 = 0;
    if (s0) mI0 = 1;
    if (s1) mI1 = 1;
  endtask

  task automatic copWrite(int a, logic [7:0] d);
    @(negedge clk);
    copWe = 1; copAddr = AW'(a); copWdata = d;
    @(posedge clk); #1;
    copWe = 0;
    mMem[a] = d;
  endtask

  task automatic copCheck(int a, string req);
    @(negedge clk);
    copAddr = AW'(a);
    #1;
    check(req, copRdata, mMem[a]);
  endtask

  task automatic outCheck(string req);
    @(negedge clk);
    check(req, hostIrq, int'(mI0 | mI1));
    check(req, copRun, int'(mRun));
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    @(negedge clk);
    check("R1 copRun", copRun, 0);
    check("R1 copIrq", copIrq, 0);
    check("R1 hostIrq", hostIrq, 0);
    hread(2'd0, "R1 status");
    hread(2'd1, "R1 addr lo");
    hread(2'd2, "R1 addr hi");

    for (int i = 0; i < DEPTH; i++) copWrite(i, patt(i));

    // R2 independent byte loads
    hwrite(2'd1, 8'h34); hread(2'd2, "R2 hi kept"); hread(2'd1, "R2 lo");
    hwrite(2'd2, 8'h12); hread(2'd1, "R2 lo kept"); hread(2'd2, "R2 hi");

    // R4 no auto-increment: pointer holds
    hread(2'd3, "R3 read data");
    hread(2'd1, "R4 no step lo");

    // R6 run + auto-increment
    hwrite(2'd0, 8'h03);
    outCheck("R6 run out");
    hread(2'd0, "R6 status");

    // R3/R4 streaming writes then readback
    hwrite(2'd1, 8'h40); hwrite(2'd2, 8'h00);
    for (int i = 0; i < 8; i++) hwrite(2'd3, 8'(8'hA0 + i));
    hread(2'd1, "R4 stepped lo");
    for (int i = 0; i < 8; i++) copCheck(16'h40 + i, "R3 cop sees host write");
    hwrite(2'd1, 8'h40);
    for (int i = 0; i < 8; i++) hread(2'd3, "R3 stream read");

    // R5 wrap
    hwrite(2'd1, 8'hFF); hwrite(2'd2, 8'hFF);
    hread(2'd3, "R5 read at top");
    hread(2'd1, "R5 wrap lo");
    hread(2'd2, "R5 wrap hi");

    // R3 liveness byte handshake, auto-increment off
    hwrite(2'd0, 8'h01);
    copWrite(16'h20, 8'hFF);
    hwrite(2'd1, 8'h20); hwrite(2'd2, 8'h00);
    hread(2'd3, "R3 alive read");
    hwrite(2'd3, 8'h00);
    copCheck(16'h20, "R3 alive cleared");

    // R7 coprocessor interrupt pulse
    hwrite(2'd0, 8'h07);
    @(negedge clk); check("R7 pulse high", copIrq, 1);
    @(negedge clk); check("R7 pulse one cycle", copIrq, 0);
    hread(2'd0, "R7 irq bit reads 0");
    hwrite(2'd0, 8'h06);
    @(negedge clk); check("R7 no pulse when stopped", copIrq, 0);
    hwrite(2'd0, 8'h03);

    // R8 flags and OR
    copSet(1, 0); outCheck("R8 int0 irq"); hread(2'd0, "R8 status int0");
    copSet(0, 1); hread(2'd0, "R8 status both");
    // R9 clear one only
    hwrite(2'd0, 8'h13); hread(2'd0, "R9 clear int0 only"); outCheck("R9 irq still");
    hwrite(2'd0, 8'h03); hread(2'd0, "R9 zero leaves int1");
    hwrite(2'd0, 8'h23); outCheck("R9 irq drops");

    // R10 same-cycle set and clear
    @(negedge clk);
    hostSel = 1; hostWe = 1; hostReg = 2'd0; hostWdata = 8'h13; copSetInt0 = 1;
    @(posedge clk); #1;
    hostSel = 0; hostWe = 0; copSetInt0 = 0;
    mI0 = 1; mRun = 1; mAuto = 1;
    hread(2'd0, "R10 set wins");
    hwrite(2'd0, 8'h13);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: hwrite(2'd1, 8'($urandom));
        1: hwrite(2'd2, 8'($urandom_range(0, 255)));
        2, 3: hwrite(2'd3, 8'($urandom));
        4, 5: hread(2'd3, "R3 random read");
        6: hwrite(2'd0, 8'($urandom) & 8'h33);
        7: hread(2'd0, "R6 random status");
        8: copSet(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
        default: hread(2'($urandom_range(1, 2)), "R2 random addr");
      endcase
      if (n % 50 == 0) outCheck("R8 random outputs");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule